// File: doc/BRIEF.md
# I2C Master Command and Receive Queue Interface

This block is the register-side data path of an I2C master controller. Software writes commands into one data/command register. Each write places a 9-bit entry into a transmit command queue. When bit 8 of the entry is clear, the entry is a byte to send. When bit 8 is set, the entry asks the serial engine to read one byte. Bytes that the engine receives go into a receive queue, and software reads them back through the same register, one byte per read.

Software can read the fill level of each queue. Each queue has a programmable threshold that drives a level-based status flag. A read-only parameter register reports the depths the block was built with, and an identification register returns a fixed constant. Writes to a full queue, reads from an empty one, and engine pushes into a full receive queue are dropped and each raises a one-cycle event pulse. A transfer abort empties both queues.

The serial bit engine attaches to the engine-side ports. It takes entries from the head of the command queue and pushes received bytes into the receive queue. Bus timing is not part of this block.

Top module: `i2cm_cmd_fifo_if`

## Requirements
- R1: After reset both queue levels read 0, `tx_below_thr` is 1, `rx_above_thr` is 0, `eng_cmd_valid` is 0 and all three event outputs are 0.
- R2: A write to offset 0x10 queues `reg_wdata[8:0]` unchanged. Bit 8 set marks a read request and bit 8 clear marks a transmit byte in bits [7:0]. `eng_cmd_valid` is 1 exactly while the command queue holds an entry, and `eng_cmd_data` presents the entries in write order, one per `eng_cmd_take` cycle.
- R3: Offset 0x74 reads the command queue level and offset 0x78 reads the receive queue level. Each is a plain count in the low bits with the upper bits zero, and it never exceeds the queue depth.
- R4: A read of offset 0x10 returns the oldest received byte in bits [7:0] with the upper bits zero, and removes that byte from the receive queue.
- R5: A write to offset 0x10 while the command queue is full is dropped. `tx_over_evt` is then 1 for exactly the next cycle, and the level is unchanged.
- R6: A read of offset 0x10 while the receive queue is empty returns 0. `rx_under_evt` is then 1 for exactly the next cycle.
- R7: An `eng_rx_push` while the receive queue is full is dropped. `rx_over_evt` is then 1 for exactly the next cycle, and the level is unchanged.
- R8: Offset 0x3c holds the transmit threshold and offset 0x38 holds the receive threshold. Each takes `reg_wdata[7:0]`, is limited to its depth minus 1, reads back in bits [7:0], and resets to 0.
- R9: `tx_below_thr` is 1 while the command queue level is at or below the transmit threshold. `rx_above_thr` is 1 while the receive queue level is above the receive threshold.
- R10: Offset 0xf4 reads the command queue depth minus 1 in bits [23:16] and the receive queue depth minus 1 in bits [15:8], with all other bits zero. Offset 0xfc reads 0x44570140.
- R11: A cycle with `xfer_abort` high leaves both levels at 0 in the next cycle. A queue write or engine push in that same cycle is discarded and raises no event.
- R12: Any other offset reads 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 9 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x10) |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| eng_cmd_valid | output | 1 | Command queue holds an entry |
| eng_cmd_data | output | 9 | Head command entry |
| eng_cmd_take | input | 1 | Engine removes the head command |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| xfer_abort | input | 1 | Transfer abort, empties both queues |
| tx_below_thr | output | 1 | Command level at or below its threshold |
| rx_above_thr | output | 1 | Receive level above its threshold |
| tx_over_evt | output | 1 | Pulse: write to full command queue dropped |
| rx_under_evt | output | 1 | Pulse: read of empty receive queue |
| rx_over_evt | output | 1 | Pulse: push into full receive queue dropped |

## Verification
The bench sweeps every threshold value, including values above the depth that must be limited, against every fill level from empty to full on both queues, so an off-by-one in either comparison or in the limiting shows up as a wrong flag at exactly one level. It overfills and overdrains each queue. A design that let the extra entry wrap the pointers, or did not raise the pulse, would then report a changed level, corrupt the order, or miss the event. It aborts with a write and a push arriving in the same cycle, which catches a design that leaves residue in a queue or reports a spurious overflow. It also pokes an unmapped offset, which catches a decoder that aliases a real register.

// File: rtl/i2cm_fifo_pkg.sv
package i2cm_fifo_pkg;

  localparam int unsigned CMD_W = 9;

  localparam logic [7:0] OFS_DATA  = 8'h10;
  localparam logic [7:0] OFS_RXTHR = 8'h38;
  localparam logic [7:0] OFS_TXTHR = 8'h3C;
  localparam logic [7:0] OFS_TXLVL = 8'h74;
  localparam logic [7:0] OFS_RXLVL = 8'h78;
  localparam logic [7:0] OFS_PARAM = 8'hF4;
  localparam logic [7:0] OFS_IDENT = 8'hFC;

  localparam logic [31:0] IDENT_VALUE = 32'h4457_0140;

  // Depth fields are stored as depth minus one so that 256 fits in 8 bits.
  function automatic logic [31:0] pack_depths(input logic [8:0] txd, input logic [8:0] rxd);
    logic [8:0] tm;
    logic [8:0] rm;
    tm = txd - 9'd1;
    rm = rxd - 9'd1;
    return {8'h00, tm[7:0], rm[7:0], 8'h00};
  endfunction

  function automatic logic [7:0] clamp_thr(input logic [7:0] req, input logic [7:0] lim);
    return (req > lim) ? lim : req;
  endfunction

  function automatic logic level_above(input logic [8:0] lvl, input logic [7:0] thr);
    return lvl > {1'b0, thr};
  endfunction

endpackage

// File: rtl/i2cm_sync_fifo.sv
module i2cm_sync_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

endmodule

// File: rtl/i2cm_level_flags.sv
module i2cm_level_flags
  import i2cm_fifo_pkg::*;
#(
  parameter int unsigned LW    = 3,
  parameter bit          ABOVE = 1'b0
) (
  input  logic [LW-1:0] level,
  input  logic [7:0]    thr,
  output logic          flag
);

  logic over;
  assign over = level_above(9'(level), thr);

  generate
    if (ABOVE) begin : g_above
      assign flag = over;
    end else begin : g_at_or_below
      assign flag = !over;
    end
  endgenerate

endmodule

// File: rtl/i2cm_cmd_fifo_if.sv
module i2cm_cmd_fifo_if
  import i2cm_fifo_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8,
  localparam int unsigned TX_LW   = $clog2(TX_DEPTH + 1),
  localparam int unsigned RX_LW   = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [8:0]  reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        eng_cmd_valid,
  output logic [8:0]  eng_cmd_data,
  input  logic        eng_cmd_take,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_byte,
  input  logic        xfer_abort,
  output logic        tx_below_thr,
  output logic        rx_above_thr,
  output logic        tx_over_evt,
  output logic        rx_under_evt,
  output logic        rx_over_evt
);

  localparam logic [7:0] TX_THR_MAX = 8'(TX_DEPTH - 1);
  localparam logic [7:0] RX_THR_MAX = 8'(RX_DEPTH - 1);

  logic [TX_LW-1:0] tx_level;
  logic [RX_LW-1:0] rx_level;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]       rx_head;
  logic [7:0]       tx_thr, rx_thr;

  // Decoded accesses and drop conditions, named for the checker.
  logic data_wr_hit, data_rd_hit;
  logic tx_push_drop, rx_pop_empty, rx_push_drop;

  assign data_wr_hit  = reg_wr && (reg_addr == OFS_DATA);
  assign data_rd_hit  = reg_rd && (reg_addr == OFS_DATA);
  assign tx_push_drop = data_wr_hit && tx_full && !xfer_abort;
  assign rx_pop_empty = data_rd_hit && rx_empty && !xfer_abort;
  assign rx_push_drop = eng_rx_push && rx_full && !xfer_abort;

  i2cm_sync_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (xfer_abort),
    .push     (data_wr_hit),
    .push_data(reg_wdata),
    .pop      (eng_cmd_take),
    .head     (eng_cmd_data),
    .level    (tx_level),
    .full     (tx_full),
    .empty    (tx_empty)
  );

  i2cm_sync_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (xfer_abort),
    .push     (eng_rx_push),
    .push_data(eng_rx_byte),
    .pop      (data_rd_hit),
    .head     (rx_head),
    .level    (rx_level),
    .full     (rx_full),
    .empty    (rx_empty)
  );

  assign eng_cmd_valid = !tx_empty;

  i2cm_level_flags #(.LW(TX_LW), .ABOVE(1'b0)) u_tx_flag (
    .level(tx_level), .thr(tx_thr), .flag(tx_below_thr)
  );

  i2cm_level_flags #(.LW(RX_LW), .ABOVE(1'b1)) u_rx_flag (
    .level(rx_level), .thr(rx_thr), .flag(rx_above_thr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr <= '0;
      rx_thr <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_TXTHR) tx_thr <= clamp_thr(reg_wdata[7:0], TX_THR_MAX);
      if (reg_addr == OFS_RXTHR) rx_thr <= clamp_thr(reg_wdata[7:0], RX_THR_MAX);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_over_evt  <= 1'b0;
      rx_under_evt <= 1'b0;
      rx_over_evt  <= 1'b0;
    end else begin
      tx_over_evt  <= tx_push_drop;
      rx_under_evt <= rx_pop_empty;
      rx_over_evt  <= rx_push_drop;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_DATA:  reg_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
      OFS_RXTHR: reg_rdata = {24'h0, rx_thr};
      OFS_TXTHR: reg_rdata = {24'h0, tx_thr};
      OFS_TXLVL: reg_rdata = 32'(tx_level);
      OFS_RXLVL: reg_rdata = 32'(rx_level);
      OFS_PARAM: reg_rdata = pack_depths(9'(TX_DEPTH), 9'(RX_DEPTH));
      OFS_IDENT: reg_rdata = IDENT_VALUE;
      default:   reg_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/i2cm_cmd_fifo_chk.sv
module i2cm_cmd_fifo_chk
  import i2cm_fifo_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8,
  localparam int unsigned TX_LW   = $clog2(TX_DEPTH + 1),
  localparam int unsigned RX_LW   = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [31:0]      reg_rdata,
  input logic             eng_cmd_valid,
  input logic             eng_cmd_take,
  input logic             eng_rx_push,
  input logic             xfer_abort,
  input logic [TX_LW-1:0] tx_level,
  input logic [RX_LW-1:0] rx_level,
  input logic [7:0]       tx_thr,
  input logic [7:0]       rx_thr,
  input logic             tx_over_evt,
  input logic             rx_under_evt,
  input logic             rx_over_evt,
  input logic             rx_above_thr
);

  p_cmd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid == (tx_level != '0));

  p_level_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= TX_LW'(TX_DEPTH)) && (rx_level <= RX_LW'(RX_DEPTH)));

  p_tx_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_DATA && tx_level == TX_LW'(TX_DEPTH) && !xfer_abort && !eng_cmd_take)
    |=> (tx_over_evt && tx_level == TX_LW'(TX_DEPTH)));

  p_under_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_DATA && rx_level == '0) |-> (reg_rdata == 32'h0));

  p_under_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_DATA && rx_level == '0 && !xfer_abort) |=> rx_under_evt);

  p_rx_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && rx_level == RX_LW'(RX_DEPTH) && !xfer_abort && !(reg_rd && reg_addr == OFS_DATA))
    |=> (rx_over_evt && rx_level == RX_LW'(RX_DEPTH)));

  p_thr_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_thr <= 8'(TX_DEPTH - 1)) && (rx_thr <= 8'(RX_DEPTH - 1)));

  p_rx_flag_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_above_thr |-> (rx_level != '0));

  p_abort_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> (tx_level == '0 && rx_level == '0 && !tx_over_evt && !rx_over_evt && !rx_under_evt));

endmodule

bind i2cm_cmd_fifo_if i2cm_cmd_fifo_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_rdata    (reg_rdata),
  .eng_cmd_valid(eng_cmd_valid),
  .eng_cmd_take (eng_cmd_take),
  .eng_rx_push  (eng_rx_push),
  .xfer_abort   (xfer_abort),
  .tx_level     (tx_level),
  .rx_level     (rx_level),
  .tx_thr       (tx_thr),
  .rx_thr       (rx_thr),
  .tx_over_evt  (tx_over_evt),
  .rx_under_evt (rx_under_evt),
  .rx_over_evt  (rx_over_evt),
  .rx_above_thr (rx_above_thr)
);

// File: tb/test_i2cm_cmd_fifo_if.sv
`timescale 1ns/1ps
module test_i2cm_cmd_fifo_if;

  localparam int TXD = 4;
  localparam int RXD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_wdata = 9'h0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        eng_cmd_valid;
  logic [8:0]  eng_cmd_data;
  logic        eng_cmd_take = 1'b0;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_byte = 8'h0;
  logic        xfer_abort = 1'b0;
  logic        tx_below_thr, rx_above_thr, tx_over_evt, rx_under_evt, rx_over_evt;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  i2cm_cmd_fifo_if #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_i2cm_cmd_fifo_if (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .eng_cmd_valid(eng_cmd_valid),
    .eng_cmd_data(eng_cmd_data), .eng_cmd_take(eng_cmd_take), .eng_rx_push(eng_rx_push),
    .eng_rx_byte(eng_rx_byte), .xfer_abort(xfer_abort), .tx_below_thr(tx_below_thr),
    .rx_above_thr(rx_above_thr), .tx_over_evt(tx_over_evt), .rx_under_evt(rx_under_evt),
    .rx_over_evt(rx_over_evt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [8:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    eng_rx_byte = b; eng_rx_push = 1'b1;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic cmd_take();
    @(negedge clk);
    eng_cmd_take = 1'b1;
    @(negedge clk);
    eng_cmd_take = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk);
    xfer_abort = 1'b1;
    @(negedge clk);
    xfer_abort = 1'b0;
  endtask

  function automatic int lim(input int v, input int d);
    return (v > d - 1) ? d - 1 : v;
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(8'h74, d); check("R1 tx level", d, 0);
    peek(8'h78, d); check("R1 rx level", d, 0);
    check("R1 tx_below_thr", 32'(tx_below_thr), 1);
    check("R1 rx_above_thr", 32'(rx_above_thr), 0);
    check("R1 eng_cmd_valid", 32'(eng_cmd_valid), 0);
    check("R1 events", {29'h0, tx_over_evt, rx_under_evt, rx_over_evt}, 0);

    // R10 self-description
    peek(8'hF4, d); check("R10 param", d, {8'h0, 8'(TXD - 1), 8'(RXD - 1), 8'h0});
    peek(8'hFC, d); check("R10 ident", d, 32'h4457_0140);

    // R12 unmapped offset
    peek(8'h14, d); check("R12 unmapped read", d, 0);
    bus_write(8'h14, 9'h1FF);
    peek(8'h74, d); check("R12 unmapped write tx level", d, 0);
    peek(8'h3C, d); check("R12 unmapped write tx thr", d, 0);

    // R8 threshold limiting sweep
    for (int t = 0; t < 7; t++) begin
      bus_write(8'h3C, 9'(t));
      peek(8'h3C, d); check("R8 tx thr", d, 32'(lim(t, TXD)));
      bus_write(8'h38, 9'(t + 1));
      peek(8'h38, d); check("R8 rx thr", d, 32'(lim(t + 1, RXD)));
    end

    // R9 exhaustive threshold x level, command side
    for (int t = 0; t < TXD; t++) begin
      bus_write(8'h3C, 9'(t));
      for (int l = 0; l <= TXD; l++) begin
        @(negedge clk); #1;
        check("R9 tx_below_thr", 32'(tx_below_thr), 32'(l <= t));
        if (l < TXD) bus_write(8'h10, 9'h055);
      end
      do_abort();
    end

    // R9 exhaustive threshold x level, receive side
    for (int t = 0; t < RXD; t++) begin
      bus_write(8'h38, 9'(t));
      for (int l = 0; l <= RXD; l++) begin
        @(negedge clk); #1;
        check("R9 rx_above_thr", 32'(rx_above_thr), 32'(l > t));
        if (l < RXD) rx_push(8'h11);
      end
      do_abort();
    end

    // R2 / R3 / R5 command queue fill, overflow and drain
    for (int i = 0; i < TXD; i++) begin
      bus_write(8'h10, {1'(i % 2), 8'(8'hA0 + i)});
      peek(8'h74, d); check("R3 tx level fill", d, 32'(i + 1));
    end
    bus_write(8'h10, 9'h0EE);
    check("R5 tx_over pulse", 32'(tx_over_evt), 1);
    peek(8'h74, d); check("R5 tx level held", d, 32'(TXD));
    check("R5 tx_over one cycle", 32'(tx_over_evt), 0);
    for (int i = 0; i < TXD; i++) begin
      @(negedge clk); #1;
      check("R2 cmd valid", 32'(eng_cmd_valid), 1);
      check("R2 cmd order", 32'(eng_cmd_data), 32'({1'(i % 2), 8'(8'hA0 + i)}));
      cmd_take();
    end
    check("R2 cmd valid empty", 32'(eng_cmd_valid), 0);
    cmd_take();
    peek(8'h74, d); check("R3 tx level after empty take", d, 0);

    // R4 / R6 / R7 receive queue
    for (int i = 0; i < RXD; i++) begin
      rx_push(8'(8'h30 + 7 * i));
      peek(8'h78, d); check("R3 rx level fill", d, 32'(i + 1));
    end
    rx_push(8'hFF);
    check("R7 rx_over pulse", 32'(rx_over_evt), 1);
    peek(8'h78, d); check("R7 rx level held", d, 32'(RXD));
    check("R7 rx_over one cycle", 32'(rx_over_evt), 0);
    for (int i = 0; i < RXD; i++) begin
      bus_read(8'h10, d); check("R4 rx byte order", d, 32'(8'(8'h30 + 7 * i)));
      peek(8'h78, d); check("R4 rx level drain", d, 32'(RXD - 1 - i));
    end
    bus_read(8'h10, d); check("R6 empty read value", d, 0);
    check("R6 rx_under pulse", 32'(rx_under_evt), 1);
    @(negedge clk);
    check("R6 rx_under one cycle", 32'(rx_under_evt), 0);

    // R11 abort with concurrent write and push
    bus_write(8'h10, 9'h101);
    bus_write(8'h10, 9'h022);
    rx_push(8'h5A);
    @(negedge clk);
    xfer_abort = 1'b1; reg_addr = 8'h10; reg_wdata = 9'h033; reg_wr = 1'b1;
    eng_rx_push = 1'b1; eng_rx_byte = 8'h77;
    @(negedge clk);
    xfer_abort = 1'b0; reg_wr = 1'b0; eng_rx_push = 1'b0;
    #1;
    check("R11 no tx_over", 32'(tx_over_evt), 0);
    check("R11 no rx_over", 32'(rx_over_evt), 0);
    peek(8'h74, d); check("R11 tx level flushed", d, 0);
    peek(8'h78, d); check("R11 rx level flushed", d, 0);
    check("R11 cmd valid", 32'(eng_cmd_valid), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule